// File: doc/BRIEF.md
# Garbled Session Release Guard

This block sits on the token side of a garbled-circuit session and decides whether the computed result may ever be released. While the token streams out template instances of a looped garbled circuit, the generator side pulses one strobe each time an evaluator input block is consumed, one for each token input consumed, one for each gate generated, one when a template instance closes and one when generation ends. The guard counts these events against the totals loaded at session start. A missing loop iteration, a surplus or a short count, or events in the wrong order make it abort.

After generation the evaluator returns one label per output wire, in wire order. For each label the guard reads the stored label pair of that wire from the label store and checks that the returned label equals exactly one of the two. A label that equals label 1 decodes to bit 1, and one that equals label 0 decodes to bit 0. Only when the last output wire has passed are the decoded bits driven onto the result, together with a one-cycle done pulse. Any failure moves the guard into a terminal abort state. Only a power-on reset leaves that state, and the result stays zero in it. A session that has completed also cannot be restarted.

States: `S_IDLE` (waiting for start), `S_GEN` (counting generation events), `S_LWAIT` (waiting for the next output label), `S_LREQ` (store read issued), `S_LCMP` (comparing against the pair), `S_DONE` (result released, terminal), `S_ABORT` (terminal). Transitions: start with a valid config IDLE→GEN and with an invalid one IDLE→ABORT; gen_end with all counts exact GEN→LWAIT; label accepted LWAIT→LREQ; LREQ→LCMP always unless violated; match on a non-final wire LCMP→LWAIT; match on the final wire LCMP→DONE; any violation in GEN, LWAIT, LREQ or LCMP goes to ABORT.

Top module: `gsess_guard`

## Requirements
- R1: After reset the guard is idle with done_o=0, aborted_o=0, result_o=0 and st_rd_o=0.
- R2: In idle, start_i loads the four counts and cfg_outs_i. If cfg_outs_i is 0 or above MAX_OUTS the guard aborts. A start_i pulse in any other state is ignored.
- R3: The number of ev_blk_i pulses and of tk_in_i pulses during generation must equal cfg_ev_blocks_i and cfg_tk_inputs_i. A pulse beyond the limit aborts in that cycle, and a shortfall at gen_end_i aborts.
- R4: Each inst_end_i must be preceded by exactly cfg_gates_i gate_i pulses since the previous instance boundary or since start. A gate beyond that, an instance closed short, or gates still open at gen_end_i abort.
- R5: At gen_end_i the number of closed instances must equal cfg_insts_i, so a missing iteration aborts. An inst_end_i beyond cfg_insts_i aborts.
- R6: Order is enforced. lbl_valid_i during generation aborts. Any generation strobe after gen_end_i, while labels are being taken, aborts. gen_end_i in the same cycle as another generation strobe aborts, and so do gate_i and inst_end_i in the same cycle.
- R7: The k-th accepted label (k from 0) causes exactly one store read with st_rd_o=1 and st_addr_o=k in the cycle after acceptance. The store returns st_l0_i/st_l1_i one cycle later.
- R8: A returned label equal to st_l1_i only gives result bit k=1, and one equal to st_l0_i only gives bit k=0. One equal to neither, or to both, aborts.
- R9: done_o pulses for exactly one cycle, two cycles after the final label is accepted. result_o carries the decoded bits (bit k for wire k) from that cycle on and stays stable, and it is 0 before then.
- R10: Abort is sticky. Once aborted, aborted_o stays 1, done_o stays 0 and result_o stays 0 whatever the inputs, including start_i. After done, further starts and labels do not change the result or pulse done again.
- R11: A lbl_valid_i pulse while a label is still being checked (store read or compare cycle) aborts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| start_i | input | 1 | Session start, sampled in idle |
| cfg_ev_blocks_i | input | CNT_W | Expected evaluator input blocks |
| cfg_tk_inputs_i | input | CNT_W | Expected token input items |
| cfg_gates_i | input | CNT_W | Gates per template instance |
| cfg_insts_i | input | CNT_W | Expected template instances |
| cfg_outs_i | input | CNT_W | Number of output wires (1..MAX_OUTS) |
| ev_blk_i | input | 1 | Evaluator input block consumed |
| tk_in_i | input | 1 | Token input item consumed |
| gate_i | input | 1 | One gate generated |
| inst_end_i | input | 1 | Template instance closed |
| gen_end_i | input | 1 | Generation finished |
| lbl_valid_i | input | 1 | Returned output label present |
| lbl_data_i | input | LBL_W | Returned output label |
| st_rd_o | output | 1 | Label store read strobe |
| st_addr_o | output | $clog2(MAX_OUTS) | Output wire index to read |
| st_l0_i | input | LBL_W | Stored label for value 0 |
| st_l1_i | input | LBL_W | Stored label for value 1 |
| result_o | output | MAX_OUTS | Decoded result bits |
| done_o | output | 1 | One-cycle release pulse |
| aborted_o | output | 1 | Terminal abort flag |

## Verification
The bench goes after a session with one iteration short, an instance closed one gate early, and a surplus or short input count. A guard that trusted gen_end_i alone would release a reduced-round result in these cases instead of aborting. It returns a substituted label, a label matching both stored entries, and a second label while the first is still being compared. A guard that tested only one stored entry, or that sampled the store in the wrong cycle, would decode garbage or let the substitution through. It also fires start, labels and strobes after an abort and after completion. A non-sticky flag, or a guard that re-armed, would reveal a result or pulse done a second time.

// File: rtl/gsg_pkg.sv
package gsg_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_GEN   = 3'd1,
        S_LWAIT = 3'd2,
        S_LREQ  = 3'd3,
        S_LCMP  = 3'd4,
        S_DONE  = 3'd5,
        S_ABORT = 3'd6
    } gsg_state_e;
endpackage

// File: rtl/gsg_evt_ctr.sv
module gsg_evt_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] lim_i,
    input  logic         clr_i,
    input  logic         evt_i,
    output logic         full_o,
    output logic         over_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] lim_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (load_i) begin
            cnt_q <= '0;
            lim_q <= lim_i;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (evt_i && !full_o) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign full_o = (cnt_q == lim_q);
    assign over_o = evt_i && full_o;

    // R4/R3: a count never runs past its loaded limit
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim_q);
endmodule

// File: rtl/gsg_label_match.sv
module gsg_label_match #(
    parameter int LBL_W = 16
) (
    input  logic [LBL_W-1:0] got_i,
    input  logic [LBL_W-1:0] l0_i,
    input  logic [LBL_W-1:0] l1_i,
    output logic             one_o,
    output logic             bit_o
);
    logic hit0, hit1;
    always_comb begin
        hit0  = (got_i == l0_i);
        hit1  = (got_i == l1_i);
        one_o = hit0 ^ hit1;
        bit_o = hit1 && !hit0;
    end
endmodule

// File: rtl/gsess_guard.sv
module gsess_guard
    import gsg_pkg::*;
#(
    parameter int LBL_W    = 16,
    parameter int MAX_OUTS = 8,
    parameter int CNT_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [CNT_W-1:0]            cfg_ev_blocks_i,
    input  logic [CNT_W-1:0]            cfg_tk_inputs_i,
    input  logic [CNT_W-1:0]            cfg_gates_i,
    input  logic [CNT_W-1:0]            cfg_insts_i,
    input  logic [CNT_W-1:0]            cfg_outs_i,
    input  logic                        ev_blk_i,
    input  logic                        tk_in_i,
    input  logic                        gate_i,
    input  logic                        inst_end_i,
    input  logic                        gen_end_i,
    input  logic                        lbl_valid_i,
    input  logic [LBL_W-1:0]            lbl_data_i,
    output logic                        st_rd_o,
    output logic [$clog2(MAX_OUTS)-1:0] st_addr_o,
    input  logic [LBL_W-1:0]            st_l0_i,
    input  logic [LBL_W-1:0]            st_l1_i,
    output logic [MAX_OUTS-1:0]         result_o,
    output logic                        done_o,
    output logic                        aborted_o
);
    localparam int OIDX_W = $clog2(MAX_OUTS);
    localparam int NCTR   = 4;

    gsg_state_e state_q, state_d;

    logic [CNT_W-1:0]    cfg_outs_q;
    logic [OIDX_W-1:0]   out_idx_q;
    logic [LBL_W-1:0]    lbl_q;
    logic [MAX_OUTS-1:0] res_sh_q;
    logic [MAX_OUTS-1:0] res_next;
    logic [MAX_OUTS-1:0] result_q;
    logic                done_q;
    logic                g_open_q;

    logic in_gen, load, cfg_ok, last_out;
    logic gen_any, gen_viol, gen_complete;
    logic m_one, m_bit;

    logic [NCTR-1:0]       c_evt, c_clr, c_full, c_over;
    logic [NCTR-1:0][CNT_W-1:0] c_lim;

    // counter lanes: 0 evaluator blocks, 1 token inputs, 2 gates, 3 instances
    always_comb begin
        in_gen   = (state_q == S_GEN);
        load     = (state_q == S_IDLE) && start_i;
        c_lim[0] = cfg_ev_blocks_i;
        c_lim[1] = cfg_tk_inputs_i;
        c_lim[2] = cfg_gates_i;
        c_lim[3] = cfg_insts_i;
        c_evt[0] = in_gen && ev_blk_i;
        c_evt[1] = in_gen && tk_in_i;
        c_evt[2] = in_gen && gate_i;
        c_evt[3] = in_gen && inst_end_i;
        c_clr    = '0;
        c_clr[2] = in_gen && inst_end_i;
    end

    for (genvar gi = 0; gi < NCTR; gi++) begin : g_ctr
        gsg_evt_ctr #(.W(CNT_W)) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (load),
            .lim_i  (c_lim[gi]),
            .clr_i  (c_clr[gi]),
            .evt_i  (c_evt[gi]),
            .full_o (c_full[gi]),
            .over_o (c_over[gi])
        );
    end

    gsg_label_match #(.LBL_W(LBL_W)) u_match (
        .got_i (lbl_q),
        .l0_i  (st_l0_i),
        .l1_i  (st_l1_i),
        .one_o (m_one),
        .bit_o (m_bit)
    );

    always_comb begin
        cfg_ok   = (cfg_outs_i != '0) && (cfg_outs_i <= CNT_W'(MAX_OUTS));
        last_out = (CNT_W'(out_idx_q) == cfg_outs_q - CNT_W'(1));
        gen_any  = ev_blk_i || tk_in_i || gate_i || inst_end_i || gen_end_i;
        gen_complete = c_full[0] && c_full[1] && c_full[3] && !g_open_q;
        gen_viol = (|c_over)
                 || (inst_end_i && !c_full[2])
                 || (gate_i && inst_end_i)
                 || lbl_valid_i
                 || (gen_end_i && (ev_blk_i || tk_in_i || gate_i || inst_end_i))
                 || (gen_end_i && !gen_complete);
        res_next = res_sh_q;
        res_next[out_idx_q] = m_bit;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_i) state_d = cfg_ok ? S_GEN : S_ABORT;
            S_GEN: begin
                if (gen_viol)       state_d = S_ABORT;
                else if (gen_end_i) state_d = S_LWAIT;
            end
            S_LWAIT: begin
                if (gen_any)          state_d = S_ABORT;
                else if (lbl_valid_i) state_d = S_LREQ;
            end
            S_LREQ: begin
                if (gen_any || lbl_valid_i) state_d = S_ABORT;
                else                        state_d = S_LCMP;
            end
            S_LCMP: begin
                if (gen_any || lbl_valid_i || !m_one) state_d = S_ABORT;
                else if (last_out)                    state_d = S_DONE;
                else                                  state_d = S_LWAIT;
            end
            S_DONE:  state_d = S_DONE;
            S_ABORT: state_d = S_ABORT;
            default: state_d = S_ABORT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_outs_q <= '0;
            out_idx_q  <= '0;
            lbl_q      <= '0;
            res_sh_q   <= '0;
            g_open_q   <= 1'b0;
        end else begin
            if (load) begin
                cfg_outs_q <= cfg_outs_i;
                out_idx_q  <= '0;
                res_sh_q   <= '0;
                g_open_q   <= 1'b0;
            end
            if (in_gen) begin
                if (inst_end_i)  g_open_q <= 1'b0;
                else if (gate_i) g_open_q <= 1'b1;
            end
            if (state_q == S_LWAIT && lbl_valid_i) lbl_q <= lbl_data_i;
            if (state_q == S_LCMP && state_d == S_LWAIT) begin
                res_sh_q  <= res_next;
                out_idx_q <= out_idx_q + OIDX_W'(1);
            end
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= (state_q == S_LCMP) && (state_d == S_DONE);
            if ((state_q == S_LCMP) && (state_d == S_DONE)) result_q <= res_next;
        end
    end

    always_comb begin
        st_rd_o   = (state_q == S_LREQ);
        st_addr_o = out_idx_q;
        result_o  = result_q;
        done_o    = done_q;
        aborted_o = (state_q == S_ABORT);
    end

    // R9: release is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R9: result holds once released
    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE && !done_o) |-> $stable(result_o));
    // R10: abort never clears
    p_abort_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        aborted_o |=> aborted_o);
    // R10: no release once aborted, and never both flags together
    p_abort_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && aborted_o));
    // R10: result stays zero on the abort path
    p_abort_nores_r10: assert property (@(posedge clk) disable iff (!rst_n)
        aborted_o |-> (result_o == '0));
    // R7: a store read is followed by the compare cycle or an abort
    p_read_cmp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_rd_o |=> (state_q == S_LCMP || state_q == S_ABORT));
endmodule

// File: tb/sim_gsess_guard.sv
module sim_gsess_guard;
    localparam int CLK_PERIOD = 10;
    localparam int LBL_W    = 16;
    localparam int MAX_OUTS = 8;
    localparam int CNT_W    = 8;
    localparam int OIDX_W   = $clog2(MAX_OUTS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CNT_W-1:0] c_ev = '0, c_tk = '0, c_g = '0, c_ni = '0, c_no = '0;
    logic ev = 1'b0, tk = 1'b0, gt = 1'b0, ie = 1'b0, ge = 1'b0, lv = 1'b0;
    logic [LBL_W-1:0] ld = '0;
    logic st_rd;
    logic [OIDX_W-1:0] st_addr;
    logic [LBL_W-1:0] st_l0, st_l1;
    logic [MAX_OUTS-1:0] result;
    logic done, aborted;

    logic [LBL_W-1:0] mem0 [MAX_OUTS];
    logic [LBL_W-1:0] mem1 [MAX_OUTS];
    int exp_addr;
    int addr_bad = 0;
    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gsess_guard #(.LBL_W(LBL_W), .MAX_OUTS(MAX_OUTS), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .cfg_ev_blocks_i(c_ev), .cfg_tk_inputs_i(c_tk), .cfg_gates_i(c_g),
        .cfg_insts_i(c_ni), .cfg_outs_i(c_no),
        .ev_blk_i(ev), .tk_in_i(tk), .gate_i(gt), .inst_end_i(ie), .gen_end_i(ge),
        .lbl_valid_i(lv), .lbl_data_i(ld),
        .st_rd_o(st_rd), .st_addr_o(st_addr), .st_l0_i(st_l0), .st_l1_i(st_l1),
        .result_o(result), .done_o(done), .aborted_o(aborted)
    );

    // label store model, one cycle read latency; tracks expected addresses (R7)
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_addr <= 0;
        end else if (st_rd) begin
            st_l0 <= mem0[st_addr];
            st_l1 <= mem1[st_addr];
            if (int'(st_addr) != exp_addr) addr_bad <= addr_bad + 1;
            exp_addr <= exp_addr + 1;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [LBL_W-1:0] pick_label(input int k, input logic b);
        return b ? mem1[k] : mem0[k];
    endfunction

    function automatic logic [MAX_OUTS-1:0] exp_result(input logic [MAX_OUTS-1:0] bits, input int n);
        logic [MAX_OUTS-1:0] m = '0;
        for (int i = 0; i < n; i++) m[i] = 1'b1;
        return bits & m;
    endfunction

    task automatic fill_store();
        for (int k = 0; k < MAX_OUTS; k++) begin
            mem0[k] = LBL_W'($urandom);
            mem1[k] = mem0[k] ^ (LBL_W'($urandom) | LBL_W'(1));
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        {start, ev, tk, gt, ie, ge, lv} = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // mask bits: 0 ev, 1 tk, 2 gate, 3 inst_end, 4 gen_end, 5 label
    task automatic pulse(input logic [5:0] m);
        {lv, ge, ie, gt, tk, ev} = m;
        @(negedge clk);
        {lv, ge, ie, gt, tk, ev} = '0;
    endtask

    task automatic start_session(input int e, input int t, input int g, input int ni, input int no);
        c_ev = CNT_W'(e); c_tk = CNT_W'(t); c_g = CNT_W'(g); c_ni = CNT_W'(ni); c_no = CNT_W'(no);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic gen_run(input int e, input int t, input int g, input int ni, input bit do_end);
        int er = e;
        int tr = t;
        for (int i = 0; i < ni; i++) begin
            for (int j = 0; j < g; j++) begin
                logic [5:0] m = 6'b000100;
                if (er > 0 && $urandom_range(0, 1) == 1) begin m[0] = 1'b1; er--; end
                if (tr > 0 && $urandom_range(0, 1) == 1) begin m[1] = 1'b1; tr--; end
                pulse(m);
            end
            pulse(6'b001000);
        end
        while (er > 0) begin pulse(6'b000001); er--; end
        while (tr > 0) begin pulse(6'b000010); tr--; end
        if (do_end) pulse(6'b010000);
    endtask

    // returns at the cycle where done/abort of this compare is visible
    task automatic send_lbl(input logic [LBL_W-1:0] v);
        ld = v;
        lv = 1'b1;
        @(negedge clk);
        lv = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int wd = 0;
        while (wd < 150000) begin
            @(posedge clk);
            wd++;
        end
        fails++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(20240611);
        fill_store();
        do_reset();

        // R1 reset state
        check("R1 done", 64'(done), 0);
        check("R1 aborted", 64'(aborted), 0);
        check("R1 result", 64'(result), 0);
        check("R1 st_rd", 64'(st_rd), 0);

        // random complete sessions: R3 R4 R5 R7 R8 R9
        for (int s = 0; s < 24; s++) begin
            int e = $urandom_range(0, 4);
            int t = $urandom_range(0, 4);
            int g = $urandom_range(0, 5);
            int ni = $urandom_range(1, 4);
            int no = $urandom_range(1, MAX_OUTS);
            logic [MAX_OUTS-1:0] bits = MAX_OUTS'($urandom);
            int bad0 = addr_bad;
            do_reset();
            fill_store();
            start_session(e, t, g, ni, no);
            gen_run(e, t, g, ni, 1'b1);
            check("R3 R4 R5 no abort after complete generation", 64'(aborted), 0);
            for (int k = 0; k < no; k++) begin
                send_lbl(pick_label(k, bits[k]));
                if (k < no - 1) check("R9 no early done", 64'(done), 0);
            end
            check("R9 done pulse", 64'(done), 1);
            check("R8 R9 decoded result", 64'(result), 64'(exp_result(bits, no)));
            @(negedge clk);
            check("R9 done one cycle", 64'(done), 0);
            check("R9 result held", 64'(result), 64'(exp_result(bits, no)));
            check("R7 store addresses", 64'(addr_bad - bad0), 0);
            check("R7 read count", 64'(exp_addr), 64'(no));
        end

        // R10 after done: start and labels ignored
        start_session(1, 1, 1, 1, 1);
        send_lbl(mem0[0]);
        check("R10 no second done", 64'(done), 0);
        check("R10 no abort after done", 64'(aborted), 0);

        // R5 missing iteration
        do_reset();
        start_session(1, 1, 2, 3, 2);
        gen_run(1, 1, 2, 2, 1'b1);
        check("R5 missing iteration aborts", 64'(aborted), 1);
        send_lbl(mem1[0]);
        check("R10 no done after abort", 64'(done), 0);
        start_session(0, 0, 0, 0, 1);
        check("R10 start ignored after abort", 64'(aborted), 1);
        check("R10 result zero after abort", 64'(result), 0);

        // R5 extra instance
        do_reset();
        start_session(0, 0, 1, 1, 1);
        gen_run(0, 0, 1, 1, 1'b0);
        pulse(6'b001000);
        check("R5 extra instance aborts", 64'(aborted), 1);

        // R3 surplus evaluator block aborts at once
        do_reset();
        start_session(2, 0, 0, 1, 1);
        pulse(6'b000001); pulse(6'b000001);
        check("R3 at limit no abort", 64'(aborted), 0);
        pulse(6'b000001);
        check("R3 surplus block aborts", 64'(aborted), 1);

        // R3 short token input count
        do_reset();
        start_session(0, 3, 0, 1, 1);
        gen_run(0, 2, 0, 1, 1'b1);
        check("R3 short token inputs abort", 64'(aborted), 1);

        // R4 instance closed one gate short
        do_reset();
        start_session(0, 0, 3, 2, 1);
        pulse(6'b000100); pulse(6'b000100);
        pulse(6'b001000);
        check("R4 short instance aborts", 64'(aborted), 1);

        // R4 gates left open at gen_end
        do_reset();
        start_session(0, 0, 2, 1, 1);
        gen_run(0, 0, 2, 1, 1'b0);
        pulse(6'b000100);
        check("R4 open gate before end no abort yet", 64'(aborted), 0);
        pulse(6'b010000);
        check("R4 open gates at end abort", 64'(aborted), 1);

        // R6 label during generation
        do_reset();
        start_session(0, 0, 1, 1, 1);
        pulse(6'b100000);
        check("R6 label during generation aborts", 64'(aborted), 1);

        // R6 gen_end together with a gate
        do_reset();
        start_session(0, 0, 1, 1, 1);
        gen_run(0, 0, 1, 1, 1'b0);
        pulse(6'b010100);
        check("R6 gen_end with gate aborts", 64'(aborted), 1);

        // R6 strobe after gen_end
        do_reset();
        start_session(0, 0, 1, 1, 2);
        gen_run(0, 0, 1, 1, 1'b1);
        pulse(6'b000100);
        check("R6 gate after gen_end aborts", 64'(aborted), 1);

        // R8 substituted label on a middle wire
        do_reset();
        fill_store();
        start_session(0, 0, 1, 1, 3);
        gen_run(0, 0, 1, 1, 1'b1);
        send_lbl(mem1[0]);
        check("R8 first label accepted", 64'(aborted), 0);
        send_lbl(mem0[1] ^ LBL_W'(2));
        check("R8 wrong label aborts", 64'(aborted), 1);
        send_lbl(mem0[2]);
        check("R10 no done after bad label", 64'(done), 0);
        check("R10 result zero", 64'(result), 0);

        // R8 store pair with equal entries
        do_reset();
        fill_store();
        mem1[0] = mem0[0];
        start_session(0, 0, 1, 1, 1);
        gen_run(0, 0, 1, 1, 1'b1);
        send_lbl(mem0[0]);
        check("R8 both-match aborts", 64'(aborted), 1);
        check("R8 no done on both-match", 64'(done), 0);

        // R11 second label while checking
        do_reset();
        fill_store();
        start_session(0, 0, 1, 1, 2);
        gen_run(0, 0, 1, 1, 1'b1);
        ld = mem0[0];
        lv = 1'b1;
        @(negedge clk);
        @(negedge clk);
        lv = 1'b0;
        check("R11 label during check aborts", 64'(aborted), 1);

        // R2 invalid output count
        do_reset();
        start_session(0, 0, 0, 0, 0);
        check("R2 zero outputs aborts", 64'(aborted), 1);
        do_reset();
        start_session(0, 0, 0, 0, MAX_OUTS + 1);
        check("R2 too many outputs aborts", 64'(aborted), 1);

        // R2 start during generation ignored: original counts apply
        do_reset();
        fill_store();
        start_session(1, 0, 1, 1, 1);
        start_session(0, 0, 0, 0, 2);
        gen_run(1, 0, 1, 1, 1'b1);
        check("R2 second start ignored", 64'(aborted), 0);
        send_lbl(mem1[0]);
        check("R2 original output count used", 64'(done), 1);
        check("R2 result", 64'(result), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule